// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits in a 100 Mb/s receive path after descrambling and symbol alignment. It takes one aligned 5-bit code group per nibble clock and turns it into the media-independent receive outputs: a 4-bit data nibble, a data-valid flag and an error flag.

Frame boundaries come from the delimiter code groups. When the start delimiter pair arrives intact, the block reports it as two preamble nibbles and raises data-valid. It then decodes the data code groups one to one. A clean end delimiter pair closes the frame. If a start delimiter is broken, the block reports a fixed error code with data-valid held low. It then ignores the line until it has seen a run of idle code groups. Inside a frame, any code group that is not data and not the end pair is reported as an error. A frame that falls into idle without an end pair is cut short with one error nibble.

The decision for each code group looks ahead one group. Each nibble is therefore reported a fixed two clock edges after its code group is presented.

Top module: `rx_cg_decoder`

## Requirements
- R1: During reset, and whenever no frame is active, rxd is 0 and rx_dv and rx_er are 0. The idle code group is 11111. A stray non-idle code group outside a frame, other than a start code, is reported as quiet.
- R2: A start code 11000 that is immediately followed by 10001 is reported as two slots of rxd=0x5 with rx_dv high and rx_er low. rx_dv first rises on the first of these two slots.
- R3: Inside a frame, each data code group yields one nibble with rx_dv high. The encodings for 0 through F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Preamble and frame-delimiter nibbles pass through this way.
- R4: Inside a frame, 01101 immediately followed by 00111 closes the frame. Both of these slots report quiet (rx_dv low, rx_er low, rxd 0), and the block is idle afterwards.
- R5: A start code 11000 not followed by 10001 is a broken start. Its slot reports rx_er high, rx_dv low and rxd=1110, and so does every following slot until the wait of R6 ends.
- R6: After a broken start, the block returns to idle only on the slot that completes IDLE_RUN consecutive idle code groups (default 2). That slot reports quiet. Any non-idle code group during the wait, including a start pair, restarts the count and is reported as in R5.
- R7: Inside a frame, any code group other than data, or than an end pair, raises rx_er with rx_dv held high, and the frame continues. Examples are 00100, 11000, 10001, or a single idle followed by a non-idle group.
- R8: Inside a frame, 01101 not followed by 00111 is reported as an R7 error, and the frame continues.
- R9: Inside a frame, two consecutive idle code groups end the frame early. The first idle slot reports rx_er and rx_dv high. From the next slot, the outputs are quiet.
- R10: The outputs for a code group presented before clock edge k are registered at edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cg_in | input | 5 | Aligned code group, one per clock |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
Every result is due on the second rising edge after its code group is presented. One edge captures the group. The next edge registers the decision, which also uses the following group as lookahead. The bench drives a new group on each falling edge and samples the outputs on that same falling edge, before the change. It compares them with the expected values for the group driven two falling edges earlier. A separate scenario steps one start pair by hand and checks that rx_dv is still low one falling edge after the start code and high one falling edge later.

// File: rtl/rx_cg_pkg.sv
`timescale 1ns/1ps
package rx_cg_pkg;

   localparam int CG_W  = 5;
   localparam int NIB_W = 4;

   localparam logic [CG_W-1:0] CODE_IDLE = 5'b11111;
   localparam logic [CG_W-1:0] CODE_J    = 5'b11000;
   localparam logic [CG_W-1:0] CODE_K    = 5'b10001;
   localparam logic [CG_W-1:0] CODE_T    = 5'b01101;
   localparam logic [CG_W-1:0] CODE_R    = 5'b00111;

   localparam logic [NIB_W-1:0] PRE_NIB     = 4'h5;
   localparam logic [NIB_W-1:0] BAD_SSD_NIB = 4'b1110;

   typedef enum logic [2:0] {
      CG_DATA, CG_IDLE, CG_J, CG_K, CG_T, CG_R, CG_INV
   } cg_kind_e;

   typedef struct packed {
      cg_kind_e         kind;
      logic [NIB_W-1:0] nib;
   } cg_info_t;

   typedef enum logic [1:0] {
      ST_IDLE, ST_SSD_K, ST_FRAME, ST_BAD
   } rx_state_e;

   typedef struct packed {
      logic             dv;
      logic             er;
      logic [NIB_W-1:0] d;
   } mii_out_t;

   function automatic cg_info_t cg_lookup(input logic [CG_W-1:0] c);
      cg_info_t r;
      r.kind = CG_DATA;
      r.nib  = '0;
      case (c)
         5'b11110: r.nib = 4'h0;
         5'b01001: r.nib = 4'h1;
         5'b10100: r.nib = 4'h2;
         5'b10101: r.nib = 4'h3;
         5'b01010: r.nib = 4'h4;
         5'b01011: r.nib = 4'h5;
         5'b01110: r.nib = 4'h6;
         5'b01111: r.nib = 4'h7;
         5'b10010: r.nib = 4'h8;
         5'b10011: r.nib = 4'h9;
         5'b10110: r.nib = 4'hA;
         5'b10111: r.nib = 4'hB;
         5'b11010: r.nib = 4'hC;
         5'b11011: r.nib = 4'hD;
         5'b11100: r.nib = 4'hE;
         5'b11101: r.nib = 4'hF;
         CODE_IDLE: r.kind = CG_IDLE;
         CODE_J:    r.kind = CG_J;
         CODE_K:    r.kind = CG_K;
         CODE_T:    r.kind = CG_T;
         CODE_R:    r.kind = CG_R;
         default:   r.kind = CG_INV;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cg_classify.sv
`timescale 1ns/1ps
module cg_classify
   import rx_cg_pkg::*;
(
   input  logic [CG_W-1:0] code,
   output cg_info_t        info
);

   always_comb info = cg_lookup(code);

endmodule

// File: rtl/rx_cg_fsm.sv
`timescale 1ns/1ps
module rx_cg_fsm
   import rx_cg_pkg::*;
#(
   parameter int               IDLE_RUN = 2,
   parameter logic [NIB_W-1:0] ERR_FILL = '0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  cg_info_t cur,
   input  cg_info_t nxt,
   output mii_out_t slot_out
);

   localparam int CNT_W = (IDLE_RUN > 1) ? $clog2(IDLE_RUN) : 1;
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(IDLE_RUN - 1);

   generate
      if (IDLE_RUN < 1) begin : g_run_check
         $error("rx_cg_fsm: IDLE_RUN must be at least 1");
      end
   endgenerate

   rx_state_e        st_q, st_d;
   logic [CNT_W-1:0] run_q, run_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         run_q <= '0;
      end else begin
         st_q  <= st_d;
         run_q <= run_d;
      end
   end

   always_comb begin
      st_d     = st_q;
      run_d    = run_q;
      slot_out = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (cur.kind == CG_J) begin
               if (nxt.kind == CG_K) begin
                  slot_out.dv = 1'b1;
                  slot_out.d  = PRE_NIB;
                  st_d        = ST_SSD_K;
               end else begin
                  slot_out.er = 1'b1;
                  slot_out.d  = BAD_SSD_NIB;
                  st_d        = ST_BAD;
                  run_d       = '0;
               end
            end
         end
         ST_SSD_K: begin
            slot_out.dv = 1'b1;
            slot_out.d  = PRE_NIB;
            st_d        = ST_FRAME;
         end
         ST_FRAME: begin
            case (cur.kind)
               CG_DATA: begin
                  slot_out.dv = 1'b1;
                  slot_out.d  = cur.nib;
               end
               CG_T: begin
                  if (nxt.kind == CG_R) begin
                     st_d = ST_IDLE;
                  end else begin
                     slot_out.dv = 1'b1;
                     slot_out.er = 1'b1;
                     slot_out.d  = ERR_FILL;
                  end
               end
               CG_IDLE: begin
                  slot_out.dv = 1'b1;
                  slot_out.er = 1'b1;
                  slot_out.d  = ERR_FILL;
                  if (nxt.kind == CG_IDLE) st_d = ST_IDLE;
               end
               default: begin
                  slot_out.dv = 1'b1;
                  slot_out.er = 1'b1;
                  slot_out.d  = ERR_FILL;
               end
            endcase
         end
         ST_BAD: begin
            if (cur.kind == CG_IDLE && run_q == RUN_LAST) begin
               st_d  = ST_IDLE;
               run_d = '0;
            end else begin
               slot_out.er = 1'b1;
               slot_out.d  = BAD_SSD_NIB;
               run_d       = (cur.kind == CG_IDLE) ? run_q + 1'b1 : '0;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // R6: a non-idle group while waiting never ends the wait
   assert_bad_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BAD && cur.kind != CG_IDLE) |=> (st_q == ST_BAD));

   // R2: the second start slot is only ever reached from idle
   assert_ssd_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SSD_K) |-> ($past(st_q) == ST_IDLE));

endmodule

// File: rtl/rx_out_stage.sv
`timescale 1ns/1ps
module rx_out_stage
   import rx_cg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  mii_out_t         slot_in,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd   <= '0;
         rx_dv <= 1'b0;
         rx_er <= 1'b0;
      end else begin
         rxd   <= slot_in.d;
         rx_dv <= slot_in.dv;
         rx_er <= slot_in.er;
      end
   end

   assert_quiet_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_dv && !rx_er) |-> (rxd == '0));

   assert_bad_ssd_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_er && !rx_dv) |-> (rxd == BAD_SSD_NIB));

   assert_ssd_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |-> (rxd == PRE_NIB && !rx_er));

   assert_ssd_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv) |=> (rx_dv && rxd == PRE_NIB));

endmodule

// File: rtl/rx_cg_decoder.sv
`timescale 1ns/1ps
module rx_cg_decoder
   import rx_cg_pkg::*;
#(
   parameter int               IDLE_RUN = 2,
   parameter logic [NIB_W-1:0] ERR_FILL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CG_W-1:0]  cg_in,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_dv,
   output logic             rx_er
);

   localparam int LANES = 2;   // lane 0: group under decision, lane 1: lookahead

   logic [CG_W-1:0] cg_q;
   logic [CG_W-1:0] lane_code [LANES];
   cg_info_t        lane_info [LANES];
   mii_out_t        slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cg_q <= CODE_IDLE;
      else        cg_q <= cg_in;
   end

   assign lane_code[0] = cg_q;
   assign lane_code[1] = cg_in;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         cg_classify u_cls (
            .code (lane_code[g]),
            .info (lane_info[g])
         );
      end
   endgenerate

   rx_cg_fsm #(
      .IDLE_RUN (IDLE_RUN),
      .ERR_FILL (ERR_FILL)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (lane_info[0]),
      .nxt      (lane_info[1]),
      .slot_out (slot)
   );

   rx_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_in (slot),
      .rxd     (rxd),
      .rx_dv   (rx_dv),
      .rx_er   (rx_er)
   );

endmodule

// File: tb/rx_cg_decoder_tb.sv
`timescale 1ns/1ps
module rx_cg_decoder_tb;

   localparam logic [4:0] C_I = 5'b11111;
   localparam logic [4:0] C_J = 5'b11000;
   localparam logic [4:0] C_K = 5'b10001;
   localparam logic [4:0] C_T = 5'b01101;
   localparam logic [4:0] C_R = 5'b00111;
   localparam logic [4:0] C_H = 5'b00100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cg_in = C_I;
   logic [3:0] rxd;
   logic       rx_dv, rx_er;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_cg_decoder u_dut (
      .clk (clk), .rst_n (rst_n), .cg_in (cg_in),
      .rxd (rxd), .rx_dv (rx_dv), .rx_er (rx_er)
   );

   logic [4:0] q_cg [64];
   logic       q_dv [64];
   logic       q_er [64];
   logic       q_ck [64];
   logic [3:0] q_d  [64];
   int         q_n = 0;

   function automatic logic [4:0] dcode(input int v);
      case (v)
         0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
         4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
         8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
        12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
      endcase
   endfunction

   task automatic push(input logic [4:0] c, input logic dv, input logic er,
                       input logic [3:0] d, input logic ck);
      q_cg[q_n] = c; q_dv[q_n] = dv; q_er[q_n] = er; q_d[q_n] = d; q_ck[q_n] = ck;
      q_n++;
   endtask

   task automatic p_quiet(input logic [4:0] c);   push(c, 1'b0, 1'b0, 4'h0, 1'b1); endtask
   task automatic p_data(input logic [4:0] c, input logic [3:0] d); push(c, 1'b1, 1'b0, d, 1'b1); endtask
   task automatic p_ferr(input logic [4:0] c);    push(c, 1'b1, 1'b1, 4'h0, 1'b0); endtask
   task automatic p_bad(input logic [4:0] c);     push(c, 1'b0, 1'b1, 4'b1110, 1'b1); endtask

   task automatic check_now(input string tag, input int slot, input logic dv,
                            input logic er, input logic [3:0] d, input logic ck);
      checks++;
      if (rx_dv !== dv || rx_er !== er || (ck && rxd !== d)) begin
         errors++;
         $display("FAIL %s slot %0d: got dv=%0b er=%0b rxd=%h, expected dv=%0b er=%0b rxd=%h",
                  tag, slot, rx_dv, rx_er, rxd, dv, er, d);
      end
   endtask

   // result for the group driven at falling edge i is sampled at falling edge i+2
   task automatic run_seq(input string tag);
      for (int i = 0; i < q_n + 2; i++) begin
         @(negedge clk);
         if (i >= 2) check_now(tag, i - 2, q_dv[i-2], q_er[i-2], q_d[i-2], q_ck[i-2]);
         cg_in = (i < q_n) ? q_cg[i] : C_I;
      end
      q_n = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check_now("R1 in reset", 0, 1'b0, 1'b0, 4'h0, 1'b1);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) p_quiet(C_I);
      p_quiet(C_K);  // stray non-start group outside a frame stays quiet
      p_quiet(C_I); p_quiet(C_I);
      run_seq("R1 idle");
   endtask

   task automatic t_good_frame();
      p_quiet(C_I);
      p_data(C_J, 4'h5); p_data(C_K, 4'h5);
      p_data(dcode(5), 4'h5); p_data(dcode(5), 4'h5); p_data(dcode(13), 4'hD);
      p_data(dcode(10), 4'hA); p_data(dcode(0), 4'h0);
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R2 R3 R4 frame");
   endtask

   task automatic t_all_data();
      p_data(C_J, 4'h5); p_data(C_K, 4'h5);
      for (int v = 0; v < 16; v++) p_data(dcode(v), 4'(v));
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R3 table");
   endtask

   task automatic t_bad_ssd();
      p_quiet(C_I);
      p_bad(C_J); p_bad(dcode(5)); p_bad(dcode(5)); p_bad(C_I);
      p_quiet(C_I);
      p_data(C_J, 4'h5); p_data(C_K, 4'h5); p_data(dcode(5), 4'h5);
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R5 R6 bad start");
   endtask

   task automatic t_bad_wait();
      p_quiet(C_I);
      p_bad(C_J); p_bad(C_I); p_bad(C_J); p_bad(C_K); p_bad(C_I);
      p_quiet(C_I); p_quiet(C_I); p_quiet(C_I);
      run_seq("R6 wait");
   endtask

   task automatic t_inframe_err();
      p_data(C_J, 4'h5); p_data(C_K, 4'h5);
      p_data(dcode(1), 4'h1); p_ferr(C_H); p_data(dcode(2), 4'h2);
      p_ferr(C_J); p_data(dcode(3), 4'h3); p_ferr(C_I); p_data(dcode(4), 4'h4);
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R7 in-frame error");
   endtask

   task automatic t_t_no_r();
      p_data(C_J, 4'h5); p_data(C_K, 4'h5);
      p_data(dcode(6), 4'h6); p_ferr(C_T); p_data(dcode(7), 4'h7);
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R8 lone end code");
   endtask

   task automatic t_premature();
      p_data(C_J, 4'h5); p_data(C_K, 4'h5); p_data(dcode(3), 4'h3);
      p_ferr(C_I); p_quiet(C_I); p_quiet(C_I);
      p_data(C_J, 4'h5); p_data(C_K, 4'h5); p_data(dcode(4), 4'h4);
      p_quiet(C_T); p_quiet(C_R); p_quiet(C_I); p_quiet(C_I);
      run_seq("R9 premature end");
   endtask

   task automatic t_latency();
      @(negedge clk); cg_in = C_J;
      @(negedge clk); cg_in = C_K;
      check_now("R10 one edge", 0, 1'b0, 1'b0, 4'h0, 1'b1);
      @(negedge clk); cg_in = dcode(9);
      check_now("R10 two edges", 1, 1'b1, 1'b0, 4'h5, 1'b1);
      @(negedge clk); cg_in = C_T;
      @(negedge clk); cg_in = C_R;
      check_now("R10 data", 2, 1'b1, 1'b0, 4'h9, 1'b1);
      @(negedge clk); cg_in = C_I;
      @(negedge clk);
      @(negedge clk);
      check_now("R10 closed", 3, 1'b0, 1'b0, 4'h0, 1'b1);
   endtask

   initial begin
      t_reset();
      t_good_frame();
      t_all_data();
      t_bad_ssd();
      t_bad_wait();
      t_inframe_err();
      t_t_no_r();
      t_premature();
      t_latency();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule